// File: doc/BRIEF.md
# GPIO port controller

A sixteen-pin general-purpose I/O port. Every pin is configured through a small register bus. Each pin has five settings: a pin mode, a drive style, a pull selection, a speed class and a 4-bit peripheral function number. From these settings the block computes the controls for every pad: driver enable, driven level, pull-up and pull-down enables, and input-buffer enable. It also exports the function number of every pin, so that the peripheral side can steer its signals. Two data registers sit beside the configuration: an output data word for pins used as general outputs, and a synchronized view of the pad levels for reads.

Software writes whole registers. To change one pin's field, it reads the register, changes that field and writes the register back. A port clock-enable input models a gated bus clock. While it is low, the port neither accepts writes nor returns data. The speed class has no effect inside the block and is only passed to the pad. The bus has no handshake: a write completes on the clock edge where it is presented, and read data is a combinational function of the address.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Pin mode codes are 00 input, 01 general output, 10 peripheral function and 11 analog. The driver is enabled only in codes 01 and 10. In code 01 the driven level is the pin's bit of the output data word. `pad_ie_o` is 1 for every code except 11.
- R2: Drive style bit 0 is push-pull: `pad_oe_o` follows the driver enable and `pad_out_o` carries the level. Bit 1 is open-drain: `pad_oe_o` is 1 only when the level is 0. In open-drain, `pad_out_o` is always 0. `pad_out_o` is also 0 whenever the pin is not driving.
- R3: Pull codes are 01 pull-up and 10 pull-down. Codes 00 and 11 select no pull. Both pull enables are 0 for a pin in analog mode.
- R4: Each pin's 2-bit speed class appears unchanged at `pad_speed_o[2p+1:2p]`.
- R5: Pin p's 4-bit function number f is held at bits [4p+3:4p] of address 4 for pins 0 to 7, and at bits [4(p-8)+3:4(p-8)] of address 5 for pins 8 to 15. It appears at `af_sel_o[4p+3:4p]`. In mode 10 the pin takes its driver enable from `periph_oe_i[16f+p]` and its level from `periph_out_i[16f+p]`, and the drive style of R2 still applies.
- R6: After reset every pin's mode is analog except pins 13 and 14, which are in mode 10 with function 0. The mode register therefore reads 0xEBFFFFFF. All other registers reset to 0.
- R7: Address 7 returns, for each pin not in analog mode, the pad level sampled two clock edges earlier. Pins in analog mode read 0. Writes to address 7 are ignored.
- R8: While `port_clk_en_i` is 0, writes change no register and `bus_rdata_o` is 0 for every address.
- R9: Address map: 0 modes (2 bits per pin), 1 drive styles, 2 speeds (2 bits per pin), 3 pulls (2 bits per pin), 4 and 5 function numbers, 6 output data. Pin p's field sits at bit p, or at bits [2p+1:2p] for 2-bit fields. A write updates only the addressed register, and bits above a register's width read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released on the clock |
| port_clk_en_i | input | 1 | Port clock enable; gates register writes and reads |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| pad_in_i | input | 16 | Pad levels |
| periph_out_i | input | 256 | Peripheral levels, lane f for pin p at bit 16f+p |
| periph_oe_i | input | 256 | Peripheral driver enables, same layout |
| pad_oe_o | output | 16 | Pad driver enable |
| pad_out_o | output | 16 | Pad driven level |
| pad_pu_o | output | 16 | Pull-up enable |
| pad_pd_o | output | 16 | Pull-down enable |
| pad_ie_o | output | 16 | Digital input buffer enable |
| pad_speed_o | output | 32 | Speed class, 2 bits per pin |
| af_sel_o | output | 64 | Function number, 4 bits per pin |

## Verification
Two pairs of events can fall in the same cycle. A register write can meet a cycle in which the port clock enable is low. A pin can switch into or out of analog mode while its pad level is moving through the synchronizer. A behavioural reference model in the bench tracks each pin's settings and a two-stage delay of the pad levels. Random bus traffic, clock-enable drops and pad toggles are mixed freely, so both pairs collide often. Every clock, the model's expected read data and pad controls are compared with the outputs. Directed sequences first cover reset readback, a gated write followed by readback, single-pin read-modify-write, and input reads with a mix of analog and input pins.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int NPINS = 16;
  localparam int NAF   = 16;
  localparam int AFW   = 4;
  localparam int DW    = 32;
  localparam int AW    = 3;

  typedef enum logic [1:0] {
    MD_IN  = 2'b00,
    MD_GPO = 2'b01,
    MD_ALT = 2'b10,
    MD_ANA = 2'b11
  } pin_mode_e;

  typedef enum logic [2:0] {
    RA_MODE  = 3'd0,
    RA_OTYPE = 3'd1,
    RA_SPEED = 3'd2,
    RA_PULL  = 3'd3,
    RA_AFLO  = 3'd4,
    RA_AFHI  = 3'd5,
    RA_ODATA = 3'd6,
    RA_IDATA = 3'd7
  } reg_addr_e;

  // One bit per pin whose 2-bit mode field equals m.
  function automatic logic [NPINS-1:0] pins_in_mode(input logic [2*NPINS-1:0] mv,
                                                    input pin_mode_e m);
    logic [NPINS-1:0] r;
    for (int p = 0; p < NPINS; p++) r[p] = (mv[2*p +: 2] == m);
    return r;
  endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pkg::*;
#(
  parameter int NP        = NPINS,
  parameter int DATA_W    = DW,
  parameter int ADDR_W    = AW,
  parameter int AF_W      = AFW,
  parameter int DBG_PIN_A = 13,
  parameter int DBG_PIN_B = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clk_en_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [2*NP-1:0]      mode_o,
  output logic [NP-1:0]        otype_o,
  output logic [2*NP-1:0]      speed_o,
  output logic [2*NP-1:0]      pull_o,
  output logic [AF_W*NP-1:0]   afn_o,
  output logic [NP-1:0]        odata_o
);

  localparam int MW      = 2 * NP;
  localparam int FW      = AF_W * NP;
  localparam int AFREG_W = AF_W * (NP / 2);

  function automatic logic [MW-1:0] mode_reset_value();
    logic [MW-1:0] v;
    for (int p = 0; p < NP; p++)
      v[2*p +: 2] = ((p == DBG_PIN_A) || (p == DBG_PIN_B)) ? MD_ALT : MD_ANA;
    return v;
  endfunction

  localparam logic [MW-1:0] MODE_RST = mode_reset_value();

  logic [MW-1:0] mode_q,  mode_d;
  logic [NP-1:0] otype_q, otype_d;
  logic [MW-1:0] speed_q, speed_d;
  logic [MW-1:0] pull_q,  pull_d;
  logic [FW-1:0] afn_q,   afn_d;
  logic [NP-1:0] odata_q, odata_d;
  logic          wr_en;

  assign wr_en = we_i & clk_en_i;

  always_comb begin
    mode_d  = mode_q;
    otype_d = otype_q;
    speed_d = speed_q;
    pull_d  = pull_q;
    afn_d   = afn_q;
    odata_d = odata_q;
    if (wr_en) begin
      unique case (reg_addr_e'(addr_i))
        RA_MODE:  mode_d  = wdata_i[MW-1:0];
        RA_OTYPE: otype_d = wdata_i[NP-1:0];
        RA_SPEED: speed_d = wdata_i[MW-1:0];
        RA_PULL:  pull_d  = wdata_i[MW-1:0];
        RA_AFLO:  afn_d[AFREG_W-1:0]  = wdata_i[AFREG_W-1:0];
        RA_AFHI:  afn_d[FW-1:AFREG_W] = wdata_i[AFREG_W-1:0];
        RA_ODATA: odata_d = wdata_i[NP-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_RST;
      otype_q <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      afn_q   <= '0;
      odata_q <= '0;
    end else begin
      mode_q  <= mode_d;
      otype_q <= otype_d;
      speed_q <= speed_d;
      pull_q  <= pull_d;
      afn_q   <= afn_d;
      odata_q <= odata_d;
    end
  end

  assign mode_o  = mode_q;
  assign otype_o = otype_q;
  assign speed_o = speed_q;
  assign pull_o  = pull_q;
  assign afn_o   = afn_q;
  assign odata_o = odata_q;

  // R8
  gated_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> ($stable(mode_q) && $stable(otype_q) && $stable(speed_q) &&
                   $stable(pull_q) && $stable(afn_q) && $stable(odata_q)));

  // R6
  reset_defaults_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (mode_q == MODE_RST && otype_q == '0 && speed_q == '0 &&
                       pull_q == '0 && afn_q == '0 && odata_q == '0));

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pkg::*;
#(
  parameter int NP    = NPINS,
  parameter int LANES = NAF,
  parameter int AF_W  = AFW
) (
  input  logic [2*NP-1:0]      mode_i,
  input  logic [NP-1:0]        otype_i,
  input  logic [2*NP-1:0]      pull_i,
  input  logic [AF_W*NP-1:0]   afn_i,
  input  logic [NP-1:0]        odata_i,
  input  logic [LANES*NP-1:0]  periph_out_i,
  input  logic [LANES*NP-1:0]  periph_oe_i,
  output logic [NP-1:0]        pad_oe_o,
  output logic [NP-1:0]        pad_out_o,
  output logic [NP-1:0]        pad_pu_o,
  output logic [NP-1:0]        pad_pd_o,
  output logic [NP-1:0]        pad_ie_o
);

  for (genvar p = 0; p < NP; p++) begin : g_pin
    logic [1:0]       md;
    logic [1:0]       pl;
    logic [AF_W-1:0]  fn;
    logic [LANES-1:0] lane_val;
    logic [LANES-1:0] lane_en;
    logic             drv_en;
    logic             drv_val;
    logic             dig_on;

    assign md = mode_i[2*p +: 2];
    assign pl = pull_i[2*p +: 2];
    assign fn = afn_i[AF_W*p +: AF_W];

    for (genvar f = 0; f < LANES; f++) begin : g_lane
      assign lane_val[f] = periph_out_i[f*NP + p];
      assign lane_en[f]  = periph_oe_i[f*NP + p];
    end

    always_comb begin
      case (pin_mode_e'(md))
        MD_GPO: begin
          drv_en  = 1'b1;
          drv_val = odata_i[p];
        end
        MD_ALT: begin
          drv_en  = lane_en[fn];
          drv_val = lane_val[fn];
        end
        default: begin
          drv_en  = 1'b0;
          drv_val = 1'b0;
        end
      endcase
    end

    assign dig_on       = (md != MD_ANA);
    assign pad_oe_o[p]  = drv_en & (~otype_i[p] | ~drv_val);
    assign pad_out_o[p] = drv_en & drv_val & ~otype_i[p];
    assign pad_ie_o[p]  = dig_on;
    assign pad_pu_o[p]  = dig_on & (pl == 2'b01);
    assign pad_pd_o[p]  = dig_on & (pl == 2'b10);
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
  import gpio_pkg::*;
#(
  parameter int NP = NPINS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NP-1:0] pad_i,
  output logic [NP-1:0] sync_o
);

  logic [NP-1:0] meta_q;
  logic [NP-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

  // Edges seen since reset, for the delay check below.
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                warm_q <= '0;
    else if (warm_q != 2'd2)    warm_q <= warm_q + 2'd1;
  end

  // R7
  sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (sync_o == $past(pad_i, 2)));

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int NP        = NPINS,
  parameter int LANES     = NAF,
  parameter int AF_W      = AFW,
  parameter int DATA_W    = DW,
  parameter int ADDR_W    = AW,
  parameter int DBG_PIN_A = 13,
  parameter int DBG_PIN_B = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 port_clk_en_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  input  logic [NP-1:0]        pad_in_i,
  input  logic [LANES*NP-1:0]  periph_out_i,
  input  logic [LANES*NP-1:0]  periph_oe_i,
  output logic [NP-1:0]        pad_oe_o,
  output logic [NP-1:0]        pad_out_o,
  output logic [NP-1:0]        pad_pu_o,
  output logic [NP-1:0]        pad_pd_o,
  output logic [NP-1:0]        pad_ie_o,
  output logic [2*NP-1:0]      pad_speed_o,
  output logic [AF_W*NP-1:0]   af_sel_o
);

  localparam int MW      = 2 * NP;
  localparam int FW      = AF_W * NP;
  localparam int AFREG_W = FW / 2;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [MW-1:0] mode_w, speed_w, pull_w;
  logic [NP-1:0] otype_w, odata_w, sync_w, idata_w;
  logic [FW-1:0] afn_w;

  gpio_cfg_regs #(
    .NP(NP), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .AF_W(AF_W),
    .DBG_PIN_A(DBG_PIN_A), .DBG_PIN_B(DBG_PIN_B)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .clk_en_i (port_clk_en_i),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .mode_o   (mode_w),
    .otype_o  (otype_w),
    .speed_o  (speed_w),
    .pull_o   (pull_w),
    .afn_o    (afn_w),
    .odata_o  (odata_w)
  );

  gpio_pad_ctrl #(.NP(NP), .LANES(LANES), .AF_W(AF_W)) u_pad (
    .mode_i       (mode_w),
    .otype_i      (otype_w),
    .pull_i       (pull_w),
    .afn_i        (afn_w),
    .odata_i      (odata_w),
    .periph_out_i (periph_out_i),
    .periph_oe_i  (periph_oe_i),
    .pad_oe_o     (pad_oe_o),
    .pad_out_o    (pad_out_o),
    .pad_pu_o     (pad_pu_o),
    .pad_pd_o     (pad_pd_o),
    .pad_ie_o     (pad_ie_o)
  );

  gpio_in_sync #(.NP(NP)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .pad_i  (pad_in_i),
    .sync_o (sync_w)
  );

  assign idata_w     = sync_w & pad_ie_o;
  assign pad_speed_o = speed_w;
  assign af_sel_o    = afn_w;

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr_e'(bus_addr_i))
      RA_MODE:  rd_mux[MW-1:0]      = mode_w;
      RA_OTYPE: rd_mux[NP-1:0]      = otype_w;
      RA_SPEED: rd_mux[MW-1:0]      = speed_w;
      RA_PULL:  rd_mux[MW-1:0]      = pull_w;
      RA_AFLO:  rd_mux[AFREG_W-1:0] = afn_w[AFREG_W-1:0];
      RA_AFHI:  rd_mux[AFREG_W-1:0] = afn_w[FW-1:AFREG_W];
      RA_ODATA: rd_mux[NP-1:0]      = odata_w;
      RA_IDATA: rd_mux[NP-1:0]      = idata_w;
      default:  rd_mux = '0;
    endcase
    bus_rdata_o = port_clk_en_i ? rd_mux : '0;
  end

  // R2
  od_never_high_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (pad_oe_o & pad_out_o & otype_w) == '0);

  // R1
  idle_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (pad_oe_o & (pins_in_mode(mode_w, MD_IN) | pins_in_mode(mode_w, MD_ANA))) == '0);

  // R7
  analog_zero_read_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (port_clk_en_i && bus_addr_i == RA_IDATA) |->
      ((bus_rdata_o[NP-1:0] & pins_in_mode(mode_w, MD_ANA)) == '0));

endmodule

// File: tb/gpio_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb_top;
  import gpio_pkg::*;

  localparam int N     = NPINS;
  localparam int LANES = NAF * NPINS;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             en, we;
  logic [2:0]       addr;
  logic [31:0]      wdata, rdata;
  logic [N-1:0]     pin, oe, outv, pu, pd, ie;
  logic [2*N-1:0]   spd;
  logic [AFW*N-1:0] afs;
  logic [LANES-1:0] per_o, per_oe;

  always #2 clk = ~clk;

  gpio_port_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .port_clk_en_i(en), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_in_i(pin), .periph_out_i(per_o), .periph_oe_i(per_oe),
    .pad_oe_o(oe), .pad_out_o(outv), .pad_pu_o(pu), .pad_pd_o(pd),
    .pad_ie_o(ie), .pad_speed_o(spd), .af_sel_o(afs)
  );

  // Behavioural reference state, one entry per pin.
  int md[N], ot[N], sp[N], pl[N], af[N], od[N], s1[N], s2[N];
  int n_vec = 0, n_bad = 0;
  bit chk_on = 0, finished = 0;
  string force_tag = "";

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pack_reg(input int a);
    logic [31:0] r = '0;
    for (int p = 0; p < N; p++) begin
      case (a)
        0: r[2*p +: 2] = 2'(md[p]);
        1: r[p] = ot[p][0];
        2: r[2*p +: 2] = 2'(sp[p]);
        3: r[2*p +: 2] = 2'(pl[p]);
        4: if (p < 8)  r[4*p +: 4]     = 4'(af[p]);
        5: if (p >= 8) r[4*(p-8) +: 4] = 4'(af[p]);
        6: r[p] = od[p][0];
        default: r[p] = (md[p] != 3) && (s2[p] != 0);
      endcase
    end
    return r;
  endfunction

  task automatic compare_all();
    logic [N-1:0] eoe, eout, epu, epd, eie;
    logic [2*N-1:0] esp;
    logic [AFW*N-1:0] eaf;
    logic [31:0] erd;
    string tr;
    for (int p = 0; p < N; p++) begin
      bit d_en = 0, d_v = 0;
      if (md[p] == 1) begin d_en = 1; d_v = od[p][0]; end
      else if (md[p] == 2) begin
        d_en = per_oe[af[p]*N + p];
        d_v  = per_o[af[p]*N + p];
      end
      if (ot[p] != 0) begin eoe[p] = d_en && !d_v; eout[p] = 1'b0; end
      else            begin eoe[p] = d_en;         eout[p] = d_en && d_v; end
      eie[p] = (md[p] != 3);
      epu[p] = eie[p] && (pl[p] == 1);
      epd[p] = eie[p] && (pl[p] == 2);
      esp[2*p +: 2] = 2'(sp[p]);
      eaf[4*p +: 4] = 4'(af[p]);
    end
    erd = en ? pack_reg(int'(addr)) : 32'h0;
    if (force_tag != "") tr = force_tag;
    else if (!en)        tr = "R8";
    else if (addr == 7)  tr = "R7";
    else                 tr = "R9";
    chk(tr,   "rdata",     64'(rdata), 64'(erd));
    chk("R1", "pad_oe",    64'(oe),    64'(eoe));   // R5 lanes, R2 style
    chk("R2", "pad_out",   64'(outv),  64'(eout));
    chk("R1", "pad_ie",    64'(ie),    64'(eie));
    chk("R3", "pad_pu",    64'(pu),    64'(epu));
    chk("R3", "pad_pd",    64'(pd),    64'(epd));
    chk("R4", "pad_speed", 64'(spd),   64'(esp));
    chk("R5", "af_sel",    afs,        eaf);
  endtask

  task automatic model_commit();
    if (we && en) begin
      for (int p = 0; p < N; p++) begin
        case (addr)
          3'd0: md[p] = int'(wdata[2*p +: 2]);
          3'd1: ot[p] = int'(wdata[p]);
          3'd2: sp[p] = int'(wdata[2*p +: 2]);
          3'd3: pl[p] = int'(wdata[2*p +: 2]);
          3'd4: if (p < 8)  af[p] = int'(wdata[4*p +: 4]);
          3'd5: if (p >= 8) af[p] = int'(wdata[4*(p-8) +: 4]);
          3'd6: od[p] = int'(wdata[p]);
          default: ;
        endcase
      end
    end
    for (int p = 0; p < N; p++) begin
      s2[p] = s1[p];
      s1[p] = int'(pin[p]);
    end
  endtask

  task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d,
                      input logic e, input logic [N-1:0] pi, input string tg);
    @(negedge clk);
    if (chk_on) compare_all();
    we = w; addr = a; wdata = d; en = e; pin = pi; force_tag = tg;
    model_commit();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; en = 1'b0; we = 1'b0; addr = '0; wdata = '0; pin = '0;
    per_o = '0; per_oe = '0;
    // R6: reset state per requirement
    for (int p = 0; p < N; p++) begin
      md[p] = (p == 13 || p == 14) ? 2 : 3;
      ot[p] = 0; sp[p] = 0; pl[p] = 0; af[p] = 0; od[p] = 0; s1[p] = 0; s2[p] = 0;
    end
    for (int i = 0; i < 3; i++) step(0, 3'd0, 0, 0, '0, "");
    rst_n = 1'b1;
    chk_on = 1;
    // R6: readback of every register straight after reset
    for (int a = 0; a < 8; a++) step(0, 3'(a), 0, 1, '0, "R6");
    step(0, 3'd0, 0, 1, '0, "R6");
    @(negedge clk);
    chk("R6", "mode reset word", 64'(rdata), 64'h0000_0000_EBFF_FFFF);

    // R9: write each register, read it back, write to input data ignored
    step(1, 3'd0, 32'h5555_5555, 1, '0, "R9");
    step(1, 3'd1, 32'hFFFF_00F0, 1, '0, "R9");
    step(1, 3'd6, 32'hFFFF_A5C3, 1, '0, "R2");
    step(1, 3'd2, 32'h1B1B_E4E4, 1, '0, "R4");
    step(1, 3'd3, 32'hE4E4_1B1B, 1, '0, "R3");
    step(1, 3'd4, 32'h7654_3210, 1, '0, "R5");
    step(1, 3'd5, 32'hFEDC_BA98, 1, '0, "R5");
    step(1, 3'd7, 32'hFFFF_FFFF, 1, '0, "R7");
    for (int a = 0; a < 8; a++) step(0, 3'(a), 0, 1, '0, "R9");
    // R9: read-modify-write of pin 5's mode only
    v = pack_reg(0);
    v[11:10] = 2'b00;
    step(1, 3'd0, v, 1, '0, "R9");
    step(0, 3'd0, 0, 1, '0, "R9");

    // R8: gated write dropped, gated read zero, then readback unchanged
    step(1, 3'd0, 32'h0, 0, '0, "R8");
    step(1, 3'd6, 32'h0, 0, '0, "R8");
    step(0, 3'd0, 0, 1, '0, "R8");
    step(0, 3'd6, 0, 1, '0, "R8");

    // R7: pins 0,1 input and 2,3 analog in each group of four, pads high
    step(1, 3'd0, 32'hF0F0_F0F0, 1, '1, "R7");
    step(0, 3'd7, 0, 1, '1, "R7");
    step(0, 3'd7, 0, 1, '1, "R7");
    step(0, 3'd7, 0, 1, '1, "R7");
    @(negedge clk);
    chk("R7", "idata mixed analog", 64'(rdata), 64'h3333);

    // Random traffic: all requirements, gating and analog switches collide
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] np;
      np = ($urandom % 4 == 0) ? N'($urandom) : pin;
      step(($urandom % 3) == 0, 3'($urandom), $urandom, ($urandom % 5) != 0, np, "");
      if ($urandom % 8 == 0) begin
        for (int k = 0; k < LANES / 32; k++) begin
          per_o[32*k +: 32]  = $urandom;
          per_oe[32*k +: 32] = $urandom;
        end
      end
    end
    step(0, 3'd0, 0, 1, pin, "");
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

endmodule